// File: doc/BRIEF.md
# Integer Execute Unit with Shifter

This block is the integer datapath stage of a small load/store processor core. Each cycle the core hands it two register operands, a shift distance, a 16-bit constant with a flag that picks the constant in place of the second operand, and a 4-bit operation code. The block returns a 32-bit result in the same cycle and has no state of its own.

Ten operations are available: wrap-around addition and subtraction, bitwise AND, OR and NOR, signed and unsigned less-than compares, a logical shift in either direction, and an arithmetic right shift. The shift distance comes from its own input, so the second operand plays no part in a shift. A zero flag is raised whenever the result is zero, which lets a separate branch unit test two values for equality by subtracting them. A constant operation that subtracts is written as an addition of a negative constant.

Top module: `exec_alu`

## Requirements
- R1: Code 0 (add) returns opa_i plus the second operand, modulo 2^32, with no overflow output.
- R2: Code 1 (subtract) returns opa_i minus the second operand, modulo 2^32.
- R3: Code 2 returns the bitwise AND of the operands and code 3 returns their bitwise OR.
- R4: Code 4 returns the bitwise inverse of (opa_i OR second operand); with a zero second operand it inverts opa_i.
- R5: Code 5 returns 1 when opa_i is below the second operand as two's-complement numbers, else 0.
- R6: Code 6 returns 1 when opa_i is below the second operand as unsigned numbers, else 0.
- R7: Code 7 shifts opa_i left by shamt_i (0 to 31) filling with zeros; opb_i has no effect.
- R8: Code 8 shifts opa_i right by shamt_i filling with zeros.
- R9: Code 9 shifts opa_i right by shamt_i filling with copies of bit 31.
- R10: With imm_sel_i high, the second operand is imm_i sign-extended to 32 bits (bit 15 copied into bits 31:16) and opb_i has no effect; with it low the second operand is opb_i.
- R11: Codes 10 to 15 return zero.
- R12: zero_o is high exactly when result_o equals zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand when the constant is not selected |
| shamt_i | input | 5 | Shift distance |
| imm_i | input | 16 | Signed constant |
| imm_sel_i | input | 1 | Use the sign-extended constant as second operand |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The bench builds the block with its default widths, a 32-bit datapath, a 5-bit shift distance and a 16-bit constant. At these values every shift distance from 0 to 31 can be swept in both directions, and the sign bit of the constant sits at a position where a missing or misplaced extension shows in the upper half of the result. The 32-bit width also puts the signed and unsigned compares on the same operands, such as all ones against one, where the two must disagree.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_NOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SLTU = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_SRA  = 4'd9
    } alu_op_e;

endpackage

// File: rtl/exec_alu_opsel.sv
module exec_alu_opsel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] opb_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              imm_sel_i,
    output logic [DATA_W-1:0] opb_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        opb_o   = imm_sel_i ? imm_ext : opb_i;
    end
endmodule

// File: rtl/exec_alu_addcmp.sv
module exec_alu_addcmp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              lt_s_o,
    output logic              lt_u_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_inv;
    logic [DATA_W:0]   full;

    always_comb begin
        b_inv  = b_i ^ {DATA_W{sub_i}};
        full   = {1'b0, a_i} + {1'b0, b_inv} + {{DATA_W{1'b0}}, sub_i};
        sum_o  = full[MSB:0];
        // borrow out of a - b means a < b unsigned
        lt_u_o = ~full[DATA_W];
        // differing signs decide directly, else the difference sign does
        lt_s_o = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : full[MSB];
    end
endmodule

// File: rtl/exec_alu_shift.sv
module exec_alu_shift #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5
) (
    input  logic [DATA_W-1:0]  data_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic               left_i,
    input  logic               arith_i,
    output logic [DATA_W-1:0]  res_o
);
    localparam int MSB = DATA_W - 1;

    logic              fill;
    logic [DATA_W-1:0] stage [SHAMT_W+1];
    logic [DATA_W-1:0] flip_in;
    logic [DATA_W-1:0] flip_out;

    // a left shift is a right shift of the bit-reversed word
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            flip_in[i] = data_i[MSB-i];
        end
        fill = arith_i & ~left_i & data_i[MSB];
    end

    assign stage[0] = left_i ? flip_in : data_i;

    for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign stage[k+1] = shamt_i[k]
                          ? {{DIST{fill}}, stage[k][MSB:DIST]}
                          : stage[k];
    end

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            flip_out[i] = stage[SHAMT_W][MSB-i];
        end
        res_o = left_i ? flip_out : stage[SHAMT_W];
    end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  opa_i,
    input  logic [DATA_W-1:0]  opb_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic               imm_sel_i,
    input  logic [OP_W-1:0]    op_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               zero_o
);
    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              zero;
    } alu_res_t;

    alu_op_e           op;
    logic [DATA_W-1:0] opb_eff;
    logic [DATA_W-1:0] sum;
    logic              lt_s;
    logic              lt_u;
    logic              sub_en;
    logic              sh_left;
    logic              sh_arith;
    logic [DATA_W-1:0] shifted;
    alu_res_t          res_d;

    assign op       = alu_op_e'(op_i);
    assign sub_en   = (op != OP_ADD);
    assign sh_left  = (op == OP_SLL);
    assign sh_arith = (op == OP_SRA);

    exec_alu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) opsel_i (
        .opb_i     (opb_i),
        .imm_i     (imm_i),
        .imm_sel_i (imm_sel_i),
        .opb_o     (opb_eff)
    );

    exec_alu_addcmp #(.DATA_W(DATA_W)) addcmp_i (
        .a_i    (opa_i),
        .b_i    (opb_eff),
        .sub_i  (sub_en),
        .sum_o  (sum),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    exec_alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) shift_i (
        .data_i  (opa_i),
        .shamt_i (shamt_i),
        .left_i  (sh_left),
        .arith_i (sh_arith),
        .res_o   (shifted)
    );

    always_comb begin
        res_d = '0;
        unique case (op)
            OP_ADD,
            OP_SUB:  res_d.value = sum;
            OP_AND:  res_d.value = opa_i & opb_eff;
            OP_OR:   res_d.value = opa_i | opb_eff;
            OP_NOR:  res_d.value = ~(opa_i | opb_eff);
            OP_SLT:  res_d.value = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLTU: res_d.value = {{(DATA_W-1){1'b0}}, lt_u};
            OP_SLL,
            OP_SRL,
            OP_SRA:  res_d.value = shifted;
            default: res_d.value = '0;
        endcase
        res_d.zero = ~|res_d.value;
    end

    assign result_o = res_d.value;
    assign zero_o   = res_d.zero;
endmodule

// File: rtl/exec_alu_chk.sv
module exec_alu_chk #(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHAMT_W = 5,
    parameter int OP_W    = 4
) (
    input logic [DATA_W-1:0]  opa_i,
    input logic [DATA_W-1:0]  opb_i,
    input logic [SHAMT_W-1:0] shamt_i,
    input logic [IMM_W-1:0]   imm_i,
    input logic               imm_sel_i,
    input logic [OP_W-1:0]    op_i,
    input logic [DATA_W-1:0]  result_o,
    input logic               zero_o
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        if (!$isunknown({opa_i, opb_i, shamt_i, imm_i, imm_sel_i, op_i})) begin
            // R12
            zero_flag_chk: assert (zero_o == (result_o == '0));
            // R11
            unused_code_chk: assert (!(op_i >= 4'd10) || result_o == '0);
            // R5 R6
            slt_bool_chk: assert (!(op_i == 4'd5 || op_i == 4'd6) || result_o[MSB:1] == '0);
            // R9
            sra_sign_chk: assert (op_i != 4'd9 || result_o[MSB] == opa_i[MSB]);
            // R8
            srl_fill_chk: assert (!(op_i == 4'd8 && shamt_i != '0) || !result_o[MSB]);
            // R7
            sll_fill_chk: assert (!(op_i == 4'd7 && shamt_i != '0) || !result_o[0]);
            // R4
            nor_disjoint_chk: assert (op_i != 4'd4 || (result_o & opa_i) == '0);
            // R10
            imm_ext_chk: assert (!(op_i == 4'd0 && imm_sel_i && opa_i == '0)
                                 || result_o[MSB:IMM_W-1] == {(DATA_W-IMM_W+1){imm_i[IMM_W-1]}});
        end
    end
endmodule

bind exec_alu exec_alu_chk #(
    .DATA_W  (DATA_W),
    .IMM_W   (IMM_W),
    .SHAMT_W (SHAMT_W),
    .OP_W    (exec_alu_pkg::OP_W)
) chk_i (
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .shamt_i   (shamt_i),
    .imm_i     (imm_i),
    .imm_sel_i (imm_sel_i),
    .op_i      (op_i),
    .result_o  (result_o),
    .zero_o    (zero_o)
);

// File: tb/exec_alu_tb.sv
`timescale 1ns/1ps
module exec_alu_tb_top;

    typedef struct packed {
        logic [31:0] tag;
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  sh;
        logic [15:0] imm;
        logic        isel;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{"R1",  4'd0, 32'h0000_0005, 32'h0000_0007, 5'd0,  16'h0000, 1'b0, 32'h0000_000C},
        '{"R1",  4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0,  16'h0000, 1'b0, 32'h0000_0000},
        '{"R2",  4'd1, 32'h0000_0003, 32'h0000_0005, 5'd0,  16'h0000, 1'b0, 32'hFFFF_FFFE},
        '{"R2",  4'd1, 32'h8000_0000, 32'h0000_0001, 5'd0,  16'h0000, 1'b0, 32'h7FFF_FFFF},
        '{"R3",  4'd2, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 5'd0,  16'h0000, 1'b0, 32'h00F0_00F0},
        '{"R3",  4'd3, 32'h0000_F000, 32'h000F_0000, 5'd0,  16'h0000, 1'b0, 32'h000F_F000},
        '{"R4",  4'd4, 32'h0F0F_0000, 32'h0000_0000, 5'd0,  16'h0000, 1'b0, 32'hF0F0_FFFF},
        '{"R4",  4'd4, 32'h0000_00F0, 32'h0000_000F, 5'd0,  16'h0000, 1'b0, 32'hFFFF_FF00},
        '{"R5",  4'd5, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0,  16'h0000, 1'b0, 32'h0000_0001},
        '{"R6",  4'd6, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0,  16'h0000, 1'b0, 32'h0000_0000},
        '{"R5",  4'd5, 32'h0000_0001, 32'hFFFF_FFFF, 5'd0,  16'h0000, 1'b0, 32'h0000_0000},
        '{"R6",  4'd6, 32'h0000_0001, 32'hFFFF_FFFF, 5'd0,  16'h0000, 1'b0, 32'h0000_0001},
        '{"R5",  4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0,  16'h0000, 1'b0, 32'h0000_0001},
        '{"R5",  4'd5, 32'h0000_0005, 32'h0000_0005, 5'd0,  16'h0000, 1'b0, 32'h0000_0000},
        '{"R7",  4'd7, 32'h0000_0001, 32'hFFFF_FFFF, 5'd31, 16'h0000, 1'b0, 32'h8000_0000},
        '{"R7",  4'd7, 32'h1234_5678, 32'hFFFF_FFFF, 5'd0,  16'h0000, 1'b0, 32'h1234_5678},
        '{"R8",  4'd8, 32'h8000_0000, 32'h0000_0000, 5'd31, 16'h0000, 1'b0, 32'h0000_0001},
        '{"R8",  4'd8, 32'h1234_5678, 32'h0000_0003, 5'd8,  16'h0000, 1'b0, 32'h0012_3456},
        '{"R9",  4'd9, 32'h8000_0000, 32'h0000_0000, 5'd4,  16'h0000, 1'b0, 32'hF800_0000},
        '{"R9",  4'd9, 32'h4000_0000, 32'h0000_0000, 5'd4,  16'h0000, 1'b0, 32'h0400_0000},
        '{"R10", 4'd0, 32'h0000_0064, 32'h0000_1000, 5'd0,  16'hFFCE, 1'b1, 32'h0000_0032},
        '{"R10", 4'd0, 32'h0000_0000, 32'hFFFF_FFFF, 5'd0,  16'h7FFF, 1'b1, 32'h0000_7FFF},
        '{"R10", 4'd5, 32'hFFFF_FFF0, 32'h0000_0000, 5'd0,  16'hFFFF, 1'b1, 32'h0000_0001},
        '{"R10", 4'd2, 32'hFFFF_FFFF, 32'h0000_0000, 5'd0,  16'h8001, 1'b1, 32'hFFFF_8001},
        '{"R11", 4'd10, 32'h0000_0005, 32'h0000_0005, 5'd3, 16'h0000, 1'b0, 32'h0000_0000},
        '{"R11", 4'd15, 32'hFFFF_FFFF, 32'h1234_5678, 5'd7, 16'h1111, 1'b1, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa, opb;
    logic [4:0]  shamt;
    logic [15:0] imm;
    logic        imm_sel;
    logic [3:0]  op;
    logic [31:0] result;
    logic        zero;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10ns clk = ~clk;

    exec_alu dut_i (
        .opa_i     (opa),
        .opb_i     (opb),
        .shamt_i   (shamt),
        .imm_i     (imm),
        .imm_sel_i (imm_sel),
        .op_i      (op),
        .result_o  (result),
        .zero_o    (zero)
    );

    task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] s, input logic [15:0] im, input logic is);
        @(posedge clk);
        op = o; opa = a; opb = b; shamt = s; imm = im; imm_sel = is;
        @(negedge clk);
    endtask

    task automatic check(input logic [31:0] tag, input logic [31:0] exp);
        n_tests++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %0s result: got %h expected %h (op %0d)", tag, result, exp, op);
        end
        n_tests++;
        if (zero !== (exp == 32'h0)) begin
            n_fail++;
            $display("FAIL R12 zero flag: got %b expected %b", zero, (exp == 32'h0));
        end
    endtask

    initial begin
        op = '0; opa = '0; opb = '0; shamt = '0; imm = '0; imm_sel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: all-zero inputs give a zero sum and a raised flag (R12)
        check("R12", 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].sh, VEC[i].imm, VEC[i].isel);
            check(VEC[i].tag, VEC[i].exp);
        end

        // R9 sweep of every distance, sign bit set
        for (int k = 0; k < 32; k++) begin
            apply(4'd9, 32'h8000_0001, 32'hA5A5_A5A5, 5'(k), 16'h0, 1'b0);
            check("R9", 32'($signed(32'h8000_0001) >>> k));
        end
        // R7 and R8 sweeps
        for (int k = 0; k < 32; k++) begin
            apply(4'd7, 32'h0000_0003, 32'h0, 5'(k), 16'h0, 1'b0);
            check("R7", 32'h0000_0003 << k);
            apply(4'd8, 32'hC000_0000, 32'h0, 5'(k), 16'h0, 1'b0);
            check("R8", 32'hC000_0000 >> k);
        end
        // R2 subtracting equal values raises the zero flag
        apply(4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0, 16'h0, 1'b0);
        check("R2", 32'h0);
        // R10 constant selected low: opb_i is used
        apply(4'd0, 32'h0000_0010, 32'h0000_0020, 5'd0, 16'hFFFF, 1'b0);
        check("R10", 32'h0000_0030);
        // R6 constant compared unsigned after extension
        apply(4'd6, 32'h0000_0001, 32'h0, 5'd0, 16'h8000, 1'b1);
        check("R6", 32'h0000_0001);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule